// File: doc/BRIEF.md
# Bank-Select Alternation Watchdog and Reset Sequencer

This block watches the bank-select bit that the master sends on each valid call. While it is armed, the block counts millisecond ticks. Every valid call whose select bit differs from the previous valid call restarts the count. If the count reaches its limit before the bit changes, the block runs a fixed recovery sequence. It first pulls its data strobe low for a set number of clocks, then pulls its parameter strobe low for the same number. It then raises a reset request, signals that the data-exchange-disable flag must be set, and starts initialization. While the reset and the initialization run, it holds the data and parameter outputs inactive.

The data strobe line also acts as a reset input from outside. If the sampled line stays low for a minimum number of clocks, the block skips the strobes and goes straight to the reset and initialization. A low level that the block drives itself never counts toward this external reset. The system around the block performs the initialization and reports the end of it on `init_done`. The block then returns to idle and watches again.

Top module: `sel_alt_wdog`

## Requirements
- R1: The tick counter is held at zero, and no timeout can start, unless all of the following hold and the sequencer is idle: `comm_wd_en`=1, `ext_mode_4io`=1, `addr_nonzero`=1, `nv_write_busy`=0 and `dx_disable_flag`=0.
- R2: A cycle with `call_valid`=1 whose `sel_bit` differs from the `sel_bit` of the previous valid call since arming clears the tick counter. Changes of `sel_bit` while `call_valid`=0, and valid calls that repeat the same value, do not clear it.
- R3: When the counter holds `TIMEOUT_MS` ticks, the data strobe `dstb_pulse_n` (active low) goes low on the next clock edge and stays low for exactly `STROBE_CYC` cycles.
- R4: The parameter strobe `pstb_pulse_n` (active low) goes low on the edge where the data strobe ends and stays low for `STROBE_CYC` cycles. The two strobes are never low together. The reset request rises on the edge where the parameter strobe ends.
- R5: `ic_reset_req` stays high for `RESET_CYC` cycles. `dx_disable_set` is high only in the first of those cycles. `outs_inactive` is high from the first reset cycle until initialization ends.
- R6: `init_start` is a one-cycle pulse in the first cycle after the reset request falls. The sequencer stays in initialization until `init_done`=1 and then returns to idle.
- R7: If `dstb_pin_n` is sampled low on `EXT_RST_CYC` consecutive rising edges, `ic_reset_req` rises on the next edge with no strobes before it. Shorter lows have no effect. A long low triggers only once.
- R8: Low levels on `dstb_pin_n` that occur while the block drives its own data strobe low do not count toward the external reset.
- R9: An external reset that arrives during the parameter strobe, the reset or the initialization restarts the reset phase from its first cycle.
- R10: After `rst_n` is released, both strobes are high and `ic_reset_req`, `dx_disable_set`, `init_start` and `outs_inactive` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| comm_wd_en | input | 1 | The communication watchdog is enabled |
| ext_mode_4io | input | 1 | Extended addressing is active with the 4-in/4-out flag set |
| addr_nonzero | input | 1 | The slave address is not zero |
| nv_write_busy | input | 1 | A non-volatile memory write is in progress |
| dx_disable_flag | input | 1 | Current state of the data-exchange-disable flag |
| call_valid | input | 1 | A valid master call is present this cycle |
| sel_bit | input | 1 | Bank-select bit of the call |
| dstb_pin_n | input | 1 | Sampled level of the data strobe pin |
| init_done | input | 1 | Initialization has finished |
| dstb_pulse_n | output | 1 | Data strobe drive, active low |
| pstb_pulse_n | output | 1 | Parameter strobe drive, active low |
| ic_reset_req | output | 1 | Unconditional reset request |
| dx_disable_set | output | 1 | One-cycle request to set the disable flag |
| init_start | output | 1 | One-cycle pulse that starts initialization |
| outs_inactive | output | 1 | Hold data and parameter outputs inactive |

## Verification
All outputs are decoded directly from the sequencer state and its phase timer. A wrong sequencer state or a miscounted phase therefore appears on a strobe or the reset request within one clock. The bench compares every cycle against its own model and catches it at once. A wrong tick count, or a missed or false alternation, stays hidden until the timeout should fire. It then appears as a data strobe that starts early, late or never, up to `TIMEOUT_MS` ticks after the fault. A broken filter for the external reset shows up in two ways: a reset during the block's own data strobe, or a missing reset one edge after the required run of low samples.

// File: rtl/sel_wdog_pkg.sv
package sel_wdog_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_STROBE_D = 3'd1,
        SEQ_STROBE_P = 3'd2,
        SEQ_RESET    = 3'd3,
        SEQ_INIT     = 3'd4
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sel_alt_timer.sv
module sel_alt_timer #(
    parameter int unsigned TIMEOUT_MS = 328,
    parameter int unsigned CNT_W      = $clog2(TIMEOUT_MS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic call_valid,
    input  logic sel_bit,
    input  logic ms_tick,
    output logic expire
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_MS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev_vld;
        logic             prev_sel;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    toggled;

    always_comb begin
        st_d    = st_q;
        toggled = 1'b0;
        if (!armed) begin
            st_d = '0;
        end else begin
            toggled = call_valid && st_q.prev_vld && (sel_bit != st_q.prev_sel);
            if (call_valid) begin
                st_d.prev_vld = 1'b1;
                st_d.prev_sel = sel_bit;
            end
            if (toggled) begin
                st_d.cnt = '0;
            end else if (ms_tick && (st_q.cnt < LIMIT)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = armed && (st_q.cnt == LIMIT);

endmodule

// File: rtl/sel_ext_rst_filter.sv
module sel_ext_rst_filter #(
    parameter int unsigned EXT_RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic mask,
    output logic fire
);

    localparam int unsigned     FW   = $clog2(EXT_RST_CYC + 1);
    localparam logic [FW-1:0]   LIM  = FW'(EXT_RST_CYC);
    localparam logic [FW-1:0]   LAST = FW'(EXT_RST_CYC - 1);

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          fire;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (mask || pin_n) begin
            st_d.cnt = '0;
        end else begin
            if (st_q.cnt < LIM) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt == LAST) begin
                st_d.fire = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire = st_q.fire;

endmodule

// File: rtl/sel_rst_seq.sv
module sel_rst_seq
    import sel_wdog_pkg::*;
#(
    parameter int unsigned STROBE_CYC = 8,
    parameter int unsigned RESET_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ext_fire,
    input  logic init_done,
    output logic seq_idle,
    output logic dstb_pulse_n,
    output logic pstb_pulse_n,
    output logic ic_reset_req,
    output logic dx_disable_set,
    output logic init_start,
    output logic outs_inactive
);

    localparam int unsigned   TW       = $clog2(max2(STROBE_CYC, RESET_CYC) + 1);
    localparam logic [TW-1:0] STB_LAST = TW'(STROBE_CYC - 1);
    localparam logic [TW-1:0] RST_LAST = TW'(RESET_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [TW-1:0] tmr;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ext_fire) begin
            st_d.state = SEQ_RESET;
            st_d.tmr   = '0;
        end else begin
            unique case (st_q.state)
                SEQ_IDLE: begin
                    if (expire) begin
                        st_d.state = SEQ_STROBE_D;
                        st_d.tmr   = '0;
                    end
                end
                SEQ_STROBE_D: begin
                    if (st_q.tmr == STB_LAST) begin
                        st_d.state = SEQ_STROBE_P;
                        st_d.tmr   = '0;
                    end else begin
                        st_d.tmr = st_q.tmr + 1'b1;
                    end
                end
                SEQ_STROBE_P: begin
                    if (st_q.tmr == STB_LAST) begin
                        st_d.state = SEQ_RESET;
                        st_d.tmr   = '0;
                    end else begin
                        st_d.tmr = st_q.tmr + 1'b1;
                    end
                end
                SEQ_RESET: begin
                    if (st_q.tmr == RST_LAST) begin
                        st_d.state = SEQ_INIT;
                        st_d.tmr   = '0;
                    end else begin
                        st_d.tmr = st_q.tmr + 1'b1;
                    end
                end
                SEQ_INIT: begin
                    if (init_done) begin
                        st_d.state = SEQ_IDLE;
                        st_d.tmr   = '0;
                    end else begin
                        st_d.tmr = TW'(1);
                    end
                end
                default: begin
                    st_d.state = SEQ_IDLE;
                    st_d.tmr   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_idle       = (st_q.state == SEQ_IDLE);
    assign dstb_pulse_n   = (st_q.state != SEQ_STROBE_D);
    assign pstb_pulse_n   = (st_q.state != SEQ_STROBE_P);
    assign ic_reset_req   = (st_q.state == SEQ_RESET);
    assign dx_disable_set = (st_q.state == SEQ_RESET) && (st_q.tmr == '0);
    assign init_start     = (st_q.state == SEQ_INIT) && (st_q.tmr == '0);
    assign outs_inactive  = (st_q.state == SEQ_RESET) || (st_q.state == SEQ_INIT);

endmodule

// File: rtl/sel_alt_wdog.sv
module sel_alt_wdog #(
    parameter int unsigned TIMEOUT_MS  = 328,
    parameter int unsigned STROBE_CYC  = 8,
    parameter int unsigned RESET_CYC   = 4,
    parameter int unsigned EXT_RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic comm_wd_en,
    input  logic ext_mode_4io,
    input  logic addr_nonzero,
    input  logic nv_write_busy,
    input  logic dx_disable_flag,
    input  logic call_valid,
    input  logic sel_bit,
    input  logic dstb_pin_n,
    input  logic init_done,
    output logic dstb_pulse_n,
    output logic pstb_pulse_n,
    output logic ic_reset_req,
    output logic dx_disable_set,
    output logic init_start,
    output logic outs_inactive
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_MS + 1);

    logic seq_idle;
    logic armed;
    logic expire;
    logic ext_fire;
    logic own_strobe;

    assign armed = comm_wd_en && ext_mode_4io && addr_nonzero &&
                   !nv_write_busy && !dx_disable_flag && seq_idle;

    assign own_strobe = !dstb_pulse_n;

    sel_alt_timer #(
        .TIMEOUT_MS (TIMEOUT_MS),
        .CNT_W      (CNT_W)
    ) alt_timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .call_valid (call_valid),
        .sel_bit    (sel_bit),
        .ms_tick    (ms_tick),
        .expire     (expire)
    );

    sel_ext_rst_filter #(
        .EXT_RST_CYC (EXT_RST_CYC)
    ) ext_filter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (dstb_pin_n),
        .mask  (own_strobe),
        .fire  (ext_fire)
    );

    sel_rst_seq #(
        .STROBE_CYC (STROBE_CYC),
        .RESET_CYC  (RESET_CYC)
    ) rst_seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .expire         (expire),
        .ext_fire       (ext_fire),
        .init_done      (init_done),
        .seq_idle       (seq_idle),
        .dstb_pulse_n   (dstb_pulse_n),
        .pstb_pulse_n   (pstb_pulse_n),
        .ic_reset_req   (ic_reset_req),
        .dx_disable_set (dx_disable_set),
        .init_start     (init_start),
        .outs_inactive  (outs_inactive)
    );

endmodule

// File: rtl/sel_alt_wdog_chk.sv
module sel_alt_wdog_chk #(
    parameter int unsigned STROBE_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic dstb_pulse_n,
    input logic pstb_pulse_n,
    input logic ic_reset_req,
    input logic dx_disable_set,
    input logic init_start,
    input logic outs_inactive
);

    int unsigned dlow_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlow_run <= 0;
        end else if (!dstb_pulse_n) begin
            dlow_run <= dlow_run + 1;
        end else begin
            dlow_run <= 0;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dstb_pulse_n && !pstb_pulse_n)) else $error("strobes overlap"); // R4

    AST_DSTB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        dlow_run <= STROBE_CYC) else $error("data strobe too long"); // R3

    AST_RESET_AFTER_PSTB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pstb_pulse_n) |-> ic_reset_req) else $error("no reset after strobe"); // R4

    AST_DISABLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        dx_disable_set |-> (ic_reset_req && outs_inactive)) else $error("disable outside reset"); // R5

    AST_INIT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> ($past(ic_reset_req) && !ic_reset_req)) else $error("init without reset"); // R6

    AST_INIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start) else $error("init pulse too long"); // R6

endmodule

bind sel_alt_wdog sel_alt_wdog_chk #(
    .STROBE_CYC (STROBE_CYC)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dstb_pulse_n   (dstb_pulse_n),
    .pstb_pulse_n   (pstb_pulse_n),
    .ic_reset_req   (ic_reset_req),
    .dx_disable_set (dx_disable_set),
    .init_start     (init_start),
    .outs_inactive  (outs_inactive)
);

// File: tb/sel_alt_wdog_tb_top.sv
`timescale 1ns/1ps
module sel_alt_wdog_tb_top;

    localparam int TMO   = 328;
    localparam int STB   = 20;
    localparam int RST   = 4;
    localparam int EXT   = 6;
    localparam int TICKP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic comm_wd_en = 1'b0, ext_mode_4io = 1'b0, addr_nonzero = 1'b0;
    logic nv_write_busy = 1'b0, dx_disable_flag = 1'b0;
    logic call_valid = 1'b0, sel_bit = 1'b0, init_done = 1'b0;
    logic ext_pin_n = 1'b1;
    logic dstb_pin_n;
    logic dstb_pulse_n, pstb_pulse_n, ic_reset_req, dx_disable_set, init_start, outs_inactive;

    assign dstb_pin_n = ext_pin_n & dstb_pulse_n;

    always #2 clk = ~clk;

    sel_alt_wdog #(
        .TIMEOUT_MS (TMO), .STROBE_CYC (STB), .RESET_CYC (RST), .EXT_RST_CYC (EXT)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick),
        .comm_wd_en (comm_wd_en), .ext_mode_4io (ext_mode_4io),
        .addr_nonzero (addr_nonzero), .nv_write_busy (nv_write_busy),
        .dx_disable_flag (dx_disable_flag), .call_valid (call_valid),
        .sel_bit (sel_bit), .dstb_pin_n (dstb_pin_n), .init_done (init_done),
        .dstb_pulse_n (dstb_pulse_n), .pstb_pulse_n (pstb_pulse_n),
        .ic_reset_req (ic_reset_req), .dx_disable_set (dx_disable_set),
        .init_start (init_start), .outs_inactive (outs_inactive)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // behavioural reference: phase 0 idle, 1 data strobe, 2 param strobe, 3 reset, 4 init
    int m_ph = 0, m_t = 0, m_cnt = 0, m_flt = 0;
    bit m_pv = 0, m_ps = 0, m_fire = 0;

    // event log from the ports
    int n_dfall = 0, n_rrise = 0, n_init = 0;
    int t_dfall = 0, t_pfall = 0, t_rrise = 0, t_init = 0;
    logic pd = 1'b1, pp = 1'b1, pr = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        int tc;
        tc = cyc % TICKP;
        ms_tick <= (tc == 0) && rst_n;
    end

    always @(posedge clk) begin
        bit arm, pin, exp_hit, tog;
        int n_ph, n_t;
        cyc++;
        if (rst_n) begin
            pin = ext_pin_n && (m_ph != 1);
            arm = comm_wd_en && ext_mode_4io && addr_nonzero && !nv_write_busy
                  && !dx_disable_flag && (m_ph == 0);
            exp_hit = arm && (m_cnt == TMO);
            n_ph = m_ph;
            n_t  = m_t;
            if (m_fire) begin
                n_ph = 3; n_t = 0;
            end else if (m_ph == 0) begin
                if (exp_hit) begin n_ph = 1; n_t = 0; end
            end else if (m_ph == 1 || m_ph == 2) begin
                if (m_t == STB - 1) begin n_ph = m_ph + 1; n_t = 0; end else n_t = m_t + 1;
            end else if (m_ph == 3) begin
                if (m_t == RST - 1) begin n_ph = 4; n_t = 0; end else n_t = m_t + 1;
            end else begin
                if (init_done) begin n_ph = 0; n_t = 0; end else n_t = 1;
            end
            if (m_ph == 1 || pin) begin
                m_fire = 0; m_flt = 0;
            end else begin
                m_fire = (m_flt == EXT - 1);
                if (m_flt < EXT) m_flt++;
            end
            if (!arm) begin
                m_cnt = 0; m_pv = 0; m_ps = 0;
            end else begin
                tog = call_valid && m_pv && (sel_bit != m_ps);
                if (call_valid) begin m_pv = 1; m_ps = sel_bit; end
                if (tog) m_cnt = 0;
                else if (ms_tick && m_cnt < TMO) m_cnt++;
            end
            m_ph = n_ph;
            m_t  = n_t;
        end
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL R6 watchdog expired: cycles=%0d expected<%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(dstb_pulse_n == (m_ph != 1), "R3", "dstb_pulse_n", dstb_pulse_n, m_ph != 1);
            chk(pstb_pulse_n == (m_ph != 2), "R4", "pstb_pulse_n", pstb_pulse_n, m_ph != 2);
            chk(ic_reset_req == (m_ph == 3), "R5", "ic_reset_req", ic_reset_req, m_ph == 3);
            chk(dx_disable_set == (m_ph == 3 && m_t == 0), "R5", "dx_disable_set",
                dx_disable_set, m_ph == 3 && m_t == 0);
            chk(init_start == (m_ph == 4 && m_t == 0), "R6", "init_start",
                init_start, m_ph == 4 && m_t == 0);
            chk(outs_inactive == (m_ph >= 3), "R5", "outs_inactive", outs_inactive, m_ph >= 3);
            if (pd && !dstb_pulse_n) begin n_dfall++; t_dfall = cyc; end
            if (pp && !pstb_pulse_n) t_pfall = cyc;
            if (!pr && ic_reset_req) begin n_rrise++; t_rrise = cyc; end
            if (init_start) begin n_init++; t_init = cyc; end
            pd = dstb_pulse_n; pp = pstb_pulse_n; pr = ic_reset_req;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic call(input bit v, input bit s);
        @(negedge clk);
        call_valid = v; sel_bit = s;
        @(negedge clk);
        call_valid = 1'b0;
    endtask

    task automatic finish_init();
        int g;
        g = 0;
        while (!outs_inactive && g < 200) begin @(negedge clk); g++; end
        wait_cyc(RST + 4);
        init_done = 1'b1;
        @(negedge clk);
        init_done = 1'b0;
        wait_cyc(2);
    endtask

    task automatic set_arm(input int off);
        comm_wd_en      = (off != 0);
        ext_mode_4io    = (off != 1);
        addr_nonzero    = (off != 2);
        nv_write_busy   = (off == 3);
        dx_disable_flag = (off == 4);
    endtask

    initial begin
        int d0, r0, g;
        set_arm(-1);
        wait_cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(dstb_pulse_n && pstb_pulse_n, "R10", "strobes high after reset", dstb_pulse_n & pstb_pulse_n, 1);
        chk(!ic_reset_req && !dx_disable_set && !init_start && !outs_inactive, "R10",
            "control outputs low after reset", ic_reset_req | init_start | outs_inactive, 0);

        // R1: one condition missing at a time, no timeout
        for (int k = 0; k < 5; k++) begin
            set_arm(k);
            d0 = n_dfall;
            wait_cyc(TMO * TICKP + 200);
            chk(n_dfall == d0, "R1", "strobe while disarmed", n_dfall - d0, 0);
        end

        // R2: alternating valid calls keep it quiet
        set_arm(-1);
        d0 = n_dfall;
        for (int k = 0; k < 10; k++) begin
            call(1'b1, k[0]);
            wait_cyc(300);
        end
        chk(n_dfall == d0, "R2", "strobe despite alternation", n_dfall - d0, 0);

        // R2: invalid toggles and same-value valid calls do not clear
        for (int k = 0; k < 6; k++) begin
            call(1'b0, ~k[0]);
            call(1'b1, 1'b1);
            wait_cyc(300);
        end
        g = 0;
        while (n_dfall == d0 && g < 3000) begin @(negedge clk); g++; end
        chk(n_dfall == d0 + 1, "R2", "timeout without alternation", n_dfall - d0, 1);

        // R3 R4 R8 R6: full sequence timing
        g = 0;
        while (n_init == 0 && g < 500) begin @(negedge clk); g++; end
        chk(t_pfall - t_dfall == STB, "R3", "data strobe width", t_pfall - t_dfall, STB);
        chk(t_rrise - t_pfall == STB, "R8", "reset only after both strobes", t_rrise - t_pfall, STB);
        chk(t_init - t_rrise == RST, "R6", "init start after reset", t_init - t_rrise, RST);
        finish_init();
        chk(!outs_inactive, "R6", "idle after init_done", outs_inactive, 0);

        // R7: short low ignored
        d0 = n_dfall; r0 = n_rrise;
        @(negedge clk); ext_pin_n = 1'b0;
        wait_cyc(EXT - 1);
        ext_pin_n = 1'b1;
        wait_cyc(20);
        chk(n_rrise == r0, "R7", "short low ignored", n_rrise - r0, 0);

        // R7: long low triggers once, without strobes
        ext_pin_n = 1'b0;
        g = cyc;
        wait_cyc(EXT + 15);
        ext_pin_n = 1'b1;
        chk(n_rrise == r0 + 1, "R7", "long low resets once", n_rrise - r0, 1);
        chk(t_rrise - g == EXT + 1, "R7", "external reset latency", t_rrise - g, EXT + 1);
        chk(n_dfall == d0, "R7", "no strobe before external reset", n_dfall - d0, 0);

        // R9: external reset during init restarts reset
        g = 0;
        while (!init_start && g < 100) begin @(negedge clk); g++; end
        wait_cyc(3);
        r0 = n_rrise;
        ext_pin_n = 1'b0;
        wait_cyc(EXT + 3);
        ext_pin_n = 1'b1;
        chk(n_rrise == r0 + 1, "R9", "reset restarted from init", n_rrise - r0, 1);
        finish_init();

        // second timeout after recovery
        d0 = n_dfall;
        wait_cyc(TMO * TICKP + 100);
        chk(n_dfall == d0 + 1, "R3", "timeout after recovery", n_dfall - d0, 1);
        finish_init();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule